// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Chain

This block models a chain of serial configuration memories that feed one shared data line. Each memory keeps an address pointer. While its chip-enable is low and its output is enabled, it presents the bit at that pointer, and it steps the pointer by one on every rising clock edge. After a memory has given out its last bit, it pulls its cascade-enable output low and stops driving. The next memory in the chain sees that low on its own chip-enable and carries on from its first bit. A host or loader can therefore read the whole chain as one long bit stream.

All memories share one reset/output-enable pin. A parameter sets its polarity. When the pin is at its reset level, every pointer goes back to the first location. When it is at the other level, output is enabled. If the pin is never pulsed, a pointer keeps its position across pauses. This lets several configuration images stored back to back be read one after another. The contents of each memory come from a fixed function of the bit's position in the chain, so every bit can be predicted.

Top module: `serial_cfg_chain`

## Requirements
- R1: While a memory is enabled (its chip-enable low, output enabled, not yet spent), it drives the bit at its pointer. Each rising clock edge advances that pointer by exactly one. The bit for global index g = device_index*DEPTH + pointer is the XOR of the low 16 bits of (g*5 + 3).
- R2: With RST_ACTIVE_HIGH=1, a high `rst_oe` means reset and a low `rst_oe` enables output. With RST_ACTIVE_HIGH=0, a low `rst_oe` means reset and a high `rst_oe` enables output.
- R3: A reset level on `rst_oe`, sampled at a rising edge, returns every pointer to 0, so `ceo_n_o` reads high afterwards. A low `rst_n` does the same at once, without waiting for a clock.
- R4: While `ce_n` is high, no memory drives (`data_oe_o` low, `data_o` low) and no pointer moves.
- R5: After a memory's last bit (pointer DEPTH-1) has been clocked out, it stops driving and drives its cascade-enable low for as long as its own chip-enable stays low. The next memory then drives its bit 0.
- R6: A spent memory's cascade-enable follows its chip-enable, so a high `ce_n` gives a high `ceo_n_o`.
- R7: Pausing with `ce_n` high, without a reset, keeps every pointer. Reading resumes at the bit after the last one read, which lets consecutive stored images be read in turn.
- R8: At most one memory drives the shared line at a time. `data_oe_o` is high exactly when one memory drives, and `data_o` is low when none drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock; one bit per rising edge |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ce_n | input | 1 | Chip-enable of the first memory, active low |
| rst_oe | input | 1 | Shared reset/output-enable pin, polarity set by RST_ACTIVE_HIGH |
| data_o | output | 1 | Resolved shared serial data line |
| data_oe_o | output | 1 | High when some memory drives the line |
| ceo_n_o | output | 1 | Cascade-enable output of the last memory, active low |

## Verification
The chain is read with one long stretch of chip-enable low that crosses both device boundaries and ends past exhaustion. This separates a correct hand-off from an early, late or overlapping drive. A half-image read followed by a pause and a resume checks that a pointer continues rather than restarts. A chip-enable that toggles every cycle checks that only the enabled edges advance the pointer. Mid-stream pin resets and an asynchronous power-on reset after the chain is spent check that a reset always brings the stream back to bit 0. Two instances with opposite pin polarity receive the same logical requests and must produce identical streams.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int unsigned GEN_MUL = 5;
  localparam int unsigned GEN_ADD = 3;
  localparam int unsigned GEN_W   = 16;

  // decoded view of the shared reset/output-enable pin
  typedef struct packed {
    logic rst;
    logic oe;
  } pin_dec_t;

  // stored content: parity of a scrambled global bit index
  function automatic logic gen_bit(input logic [31:0] gidx);
    logic [31:0]      prod;
    logic [GEN_W-1:0] v;
    prod = gidx * GEN_MUL + GEN_ADD;
    v    = prod[GEN_W-1:0];
    return ^v;
  endfunction

endpackage

// File: rtl/serial_cfg_pin_decode.sv
module serial_cfg_pin_decode
  import serial_cfg_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input  logic     pin_i,
  output pin_dec_t dec_o
);

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_high
      assign dec_o.rst = pin_i;
      assign dec_o.oe  = ~pin_i;
    end else begin : g_rst_low
      assign dec_o.rst = ~pin_i;
      assign dec_o.oe  = pin_i;
    end
  endgenerate

endmodule

// File: rtl/serial_cfg_addr_ctr.sv
module serial_cfg_addr_ctr #(
  parameter int unsigned DEPTH = 40,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             spent_o
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;
  logic             ptr_en;

  assign spent_o = (ptr_q == PTR_W'(DEPTH));
  assign ptr_o   = ptr_q;

  always_comb begin
    ptr_en  = 1'b0;
    ptr_nxt = ptr_q;
    if (clr_i) begin
      ptr_en  = 1'b1;
      ptr_nxt = '0;
    end else if (adv_i && !spent_o) begin
      ptr_en  = 1'b1;
      ptr_nxt = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_nxt;
    end
  end

endmodule

// File: rtl/serial_cfg_bit_gen.sv
module serial_cfg_bit_gen
  import serial_cfg_pkg::*;
#(
  parameter int unsigned DEV_IDX = 0,
  parameter int unsigned DEPTH   = 40,
  localparam int unsigned PTR_W  = $clog2(DEPTH + 1),
  localparam logic [31:0] BASE   = 32'(DEV_IDX * DEPTH)
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic             bit_o
);

  logic [31:0] gidx;

  assign gidx  = BASE + 32'(ptr_i);
  assign bit_o = gen_bit(gidx);

endmodule

// File: rtl/serial_cfg_mem.sv
module serial_cfg_mem
  import serial_cfg_pkg::*;
#(
  parameter int unsigned DEV_IDX         = 0,
  parameter int unsigned DEPTH           = 40,
  parameter bit          RST_ACTIVE_HIGH = 1'b0,
  localparam int unsigned PTR_W          = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic rst_oe_i,
  output logic dout_o,
  output logic doe_o,
  output logic ceo_n_o
);

  pin_dec_t         dec;
  logic [PTR_W-1:0] ptr;
  logic             spent;
  logic             cur_bit;
  logic             adv;

  serial_cfg_pin_decode #(
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
  ) u_dec (
    .pin_i (rst_oe_i),
    .dec_o (dec)
  );

  assign adv = ~ce_n_i & dec.oe;

  serial_cfg_addr_ctr #(
    .DEPTH(DEPTH)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (dec.rst),
    .adv_i   (adv),
    .ptr_o   (ptr),
    .spent_o (spent)
  );

  serial_cfg_bit_gen #(
    .DEV_IDX(DEV_IDX),
    .DEPTH  (DEPTH)
  ) u_gen (
    .ptr_i (ptr),
    .bit_o (cur_bit)
  );

  assign doe_o   = adv & ~spent;
  assign dout_o  = doe_o & cur_bit;
  assign ceo_n_o = ce_n_i | ~spent;

endmodule

// File: rtl/serial_cfg_chain.sv
module serial_cfg_chain #(
  parameter int unsigned NUM_DEV         = 3,
  parameter int unsigned DEPTH           = 40,
  parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_n_o
);

  logic [1:0]         rs_q;
  logic               rst_sync_n;
  logic [NUM_DEV:0]   ce_chain;
  logic [NUM_DEV-1:0] dev_oe;
  logic [NUM_DEV-1:0] dev_dout;
  logic [NUM_DEV-1:0] dev_ceo_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  assign ce_chain = {dev_ceo_n, ce_n};

  generate
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
      serial_cfg_mem #(
        .DEV_IDX        (i),
        .DEPTH          (DEPTH),
        .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
      ) u_mem (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .ce_n_i   (ce_chain[i]),
        .rst_oe_i (rst_oe),
        .dout_o   (dev_dout[i]),
        .doe_o    (dev_oe[i]),
        .ceo_n_o  (dev_ceo_n[i])
      );
    end
  endgenerate

  // shared line: wired-OR of the gated drivers
  assign data_o    = |(dev_dout & dev_oe);
  assign data_oe_o = |dev_oe;
  assign ceo_n_o   = ce_chain[NUM_DEV];

endmodule

// File: rtl/serial_cfg_chain_chk.sv
module serial_cfg_chain_chk #(
  parameter int unsigned NUM_DEV         = 3,
  parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_n,
  input logic               rst_oe,
  input logic               data_oe_o,
  input logic               ceo_n_o,
  input logic [NUM_DEV-1:0] dev_oe,
  input logic [NUM_DEV-1:0] dev_ceo_n
);

  logic rst_req;
  assign rst_req = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_oe)) else $error("more than one driver"); // R8

  AST_OE_MATCHES_DRIVERS: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o == ($countones(dev_oe) == 1)) else $error("line enable mismatch"); // R8

  AST_CE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!data_oe_o && ceo_n_o)) else $error("drive while disabled"); // R4

  AST_PIN_RESET_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> ceo_n_o) else $error("cascade low after reset"); // R3

  AST_HANDOFF_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dev_ceo_n[0]) && !ce_n && $past(!ce_n)) |-> $past(dev_oe[0]))
    else $error("cascade fell without a last bit"); // R5

  AST_RESET_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !data_oe_o) else $error("drive during reset level"); // R2

endmodule

bind serial_cfg_chain serial_cfg_chain_chk #(
  .NUM_DEV        (NUM_DEV),
  .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .rst_oe    (rst_oe),
  .data_oe_o (data_oe_o),
  .ceo_n_o   (ceo_n_o),
  .dev_oe    (dev_oe),
  .dev_ceo_n (dev_ceo_n)
);

// File: tb/sim_serial_cfg_chain.sv
module sim_serial_cfg_chain;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV  = 3;
  localparam int DEPTH = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n;
  logic pin0, pin1;
  logic d0, oe0, ceo0, d1, oe1, ceo1;

  int checks = 0;
  int errors = 0;
  int ptr [NDEV];

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: reset level is low; u1: reset level is high
  serial_cfg_chain #(.NUM_DEV(NDEV), .DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(pin0),
    .data_o(d0), .data_oe_o(oe0), .ceo_n_o(ceo0));

  serial_cfg_chain #(.NUM_DEV(NDEV), .DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(pin1),
    .data_o(d1), .data_oe_o(oe1), .ceo_n_o(ceo1));

  function automatic logic ref_bit(input int g);
    int v;
    logic p;
    v = (g * 5 + 3) & 16'hFFFF;
    p = 1'b0;
    for (int k = 0; k < 16; k++) p = p ^ v[k];
    return p;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input logic ce, input logic r, input string tag);
    logic c;
    logic eoe, ed;
    c = ce; eoe = 1'b0; ed = 1'b0;
    for (int d = 0; d < NDEV; d++) begin
      if (!c && !r && ptr[d] < DEPTH) begin
        eoe = 1'b1;
        ed  = ref_bit(d * DEPTH + ptr[d]);
      end
      c = c | (ptr[d] < DEPTH);
    end
    chk(tag, "u0 data_oe", oe0, eoe);
    chk(tag, "u0 data",    d0,  ed);
    chk(tag, "u0 ceo_n",   ceo0, c);
    chk(tag, "u1 data_oe (R2)", oe1, eoe);
    chk(tag, "u1 data (R2)",    d1,  ed);
    chk(tag, "u1 ceo_n (R2)",   ceo1, c);
  endtask

  task automatic model_edge(input logic ce, input logic r);
    logic c;
    logic en [NDEV];
    c = ce;
    for (int d = 0; d < NDEV; d++) begin
      en[d] = !c && !r && ptr[d] < DEPTH;
      c = c | (ptr[d] < DEPTH);
    end
    for (int d = 0; d < NDEV; d++) begin
      if (r) ptr[d] = 0;
      else if (en[d]) ptr[d] = ptr[d] + 1;
    end
  endtask

  // drive at negedge, compare, then account for the next rising edge
  task automatic step(input logic ce, input logic r, input string tag);
    ce_n = ce;
    pin0 = ~r;
    pin1 = r;
    #1;
    compare(ce, r, tag);
    @(posedge clk);
    model_edge(ce, r);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int d = 0; d < NDEV; d++) ptr[d] = 0;
    rst_n = 1'b0; ce_n = 1'b1; pin0 = 1'b0; pin1 = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    compare(1'b1, 1'b1, "R3 power-on");
    rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b1, "R3 hold");
    // R4: enabled pin but chip-enable high
    repeat (3) step(1'b1, 1'b0, "R4 idle");
    // R1: first image, 20 bits
    repeat (20) step(1'b0, 1'b0, "R1 image1");
    // R7: pause keeps pointer, then continue
    repeat (5) step(1'b1, 1'b0, "R7 pause");
    repeat (10) step(1'b0, 1'b0, "R7 resume");
    // R1: chip-enable toggling every cycle
    for (int i = 0; i < 10; i++) step(logic'(i % 2), 1'b0, "R1 toggle");
    // R3: pin reset mid-stream
    step(1'b0, 1'b1, "R3 pin reset");
    // R5/R8: read through every hand-off and past the end
    repeat (NDEV * DEPTH + 6) step(1'b0, 1'b0, "R5 R8 chain");
    // R6: spent chain follows chip-enable
    repeat (3) step(1'b1, 1'b0, "R6 ce high");
    repeat (2) step(1'b0, 1'b0, "R6 ce low");
    // R3: asynchronous power-on reset after exhaustion
    rst_n = 1'b0;
    #1;
    for (int d = 0; d < NDEV; d++) ptr[d] = 0;
    compare(1'b0, 1'b0, "R3 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b1, "R3 release");
    repeat (8) step(1'b0, 1'b0, "R1 restart");
    // R3: pin reset, then restart from bit 0
    step(1'b0, 1'b1, "R3 pin reset 2");
    repeat (6) step(1'b0, 1'b0, "R3 reread");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule